// File: doc/BRIEF.md
# Single-Precision to Brain-Float Rounding Converter

This block narrows a 32-bit single-precision floating-point word to a 16-bit brain-float word in one clocked stage. The sign and the 8-bit biased exponent carry over, and the 23-bit fraction is cut to its top 7 bits. The 16 bits that are cut decide the rounding, which is to nearest with ties going to an even result. A carry out of the fraction moves into the exponent, and the result becomes infinity with an overflow flag when that carry goes past the largest finite value.

Special encodings get their own paths. Subnormal inputs become a zero of the same sign. Infinities pass through. NaNs come out quiet: the payload is kept, and a NaN with no payload left becomes the canonical quiet NaN. An inexact flag reports that the cut bits held information for a normal input.

Each valid input gives a registered result one clock later, marked by an output valid. The outputs hold their last value while no input is valid.

Top module: `f32_to_bf16_cvt`

## Requirements
- R1: For a normal input, output bit 15 equals input bit 31, and output bits 14:0 equal input bits 30:16 when input bits 15:0 are below 0x8000.
- R2: For a normal input, output bits 14:0 equal input bits 30:16 plus one when input bits 15:0 are above 0x8000.
- R3: When input bits 15:0 equal exactly 0x8000, the result rounds up only if input bit 16 is 1, so the output's bit 0 is always 0.
- R4: A rounding carry out of the 7 fraction bits increments the exponent field (bits 14:7) and leaves the sign bit unchanged.
- R5: When rounding carries a magnitude of 0x7F7F upward, the output is 0x7F80 or 0xFF80 by sign and out_ovf is 1; otherwise out_ovf is 0.
- R6: out_inexact is 1 exactly when the input is normal and input bits 15:0 are nonzero.
- R7: An input whose exponent field (bits 30:23) is 0 produces 0x0000 or 0x8000 by sign, with both flags 0.
- R8: An input with exponent field 255 and fraction 0 produces 0x7F80 (sign 0) or 0xFF80 (sign 1), with both flags 0.
- R9: An input with exponent field 255 and nonzero fraction produces {sign, 0xFF, 1, input bits 21:16}; when input bits 21:16 are all 0, the output is 0x7FC0. Both flags are 0.
- R10: out_vld is 1 in the cycle after each cycle with in_vld high, else 0; out_word and both flags hold while in_vld is low.
- R11: While rst is high, out_vld, out_word, out_inexact and out_ovf are all 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input word is valid this cycle |
| in_word | input | 32 | Single-precision input |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_word | output | 16 | Brain-float result |
| out_inexact | output | 1 | Discarded bits of a normal input were nonzero |
| out_ovf | output | 1 | Rounding pushed a finite value to infinity |

## Verification
The bench goes after exact halfway cases with an even and an odd kept bit. A converter that truncates, or always rounds halves up, gives a result off by one unit in the last place. An all-ones kept fraction shows whether the carry reaches the exponent without touching the sign, and the largest finite magnitude shows whether an overflowing carry is flagged and lands on an infinity pattern rather than a NaN. Subnormals, signed zeros, infinities and NaNs with and without payload catch designs that round a flushed value, report a false inexact, or return a signalling or empty-fraction NaN. A long random sweep against a plain arithmetic model covers the remaining normal range.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int EXP_W      = 8;
  localparam int SRC_FRAC_W = 23;
  localparam int DST_FRAC_W = 7;
  localparam int SRC_W      = 1 + EXP_W + SRC_FRAC_W;
  localparam int DST_W      = 1 + EXP_W + DST_FRAC_W;
  localparam int MAG_W      = DST_W - 1;
  localparam int DROP_W     = SRC_FRAC_W - DST_FRAC_W;
  localparam int PAY_W      = DST_FRAC_W - 1;

  localparam logic [DST_W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {PAY_W{1'b0}}};
  localparam logic [MAG_W-1:0] MAX_FIN =
    {{(EXP_W-1){1'b1}}, 1'b0, {DST_FRAC_W{1'b1}}};
  localparam logic [MAG_W-1:0] INF_MAG =
    {{EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}};

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_SUB,
    CL_NORM,
    CL_INF,
    CL_NAN
  } cls_e;
endpackage

// File: rtl/bfc_classify.sv
module bfc_classify
  import bfc_pkg::*;
(
  input  logic [SRC_W-1:0] word,
  output cls_e             cls
);
  logic [EXP_W-1:0]      ex;
  logic [SRC_FRAC_W-1:0] fr;
  logic                  ex_zero;
  logic                  ex_ones;
  logic                  fr_zero;

  assign ex      = word[SRC_W-2 -: EXP_W];
  assign fr      = word[SRC_FRAC_W-1:0];
  assign ex_zero = (ex == '0);
  assign ex_ones = (ex == '1);
  assign fr_zero = (fr == '0);

  always_comb begin
    if (ex_zero)      cls = fr_zero ? CL_ZERO : CL_SUB;
    else if (ex_ones) cls = fr_zero ? CL_INF  : CL_NAN;
    else              cls = CL_NORM;
  end
endmodule

// File: rtl/bfc_round.sv
module bfc_round
  import bfc_pkg::*;
(
  input  logic [MAG_W-1:0]  mag,
  input  logic [DROP_W-1:0] rem,
  output logic [MAG_W-1:0]  mag_rnd,
  output logic              inexact,
  output logic              ovf
);
  logic half;
  logic sticky;
  logic bump;

  assign half    = rem[DROP_W-1];
  assign sticky  = |rem[DROP_W-2:0];
  assign bump    = half & (sticky | mag[0]);
  assign mag_rnd = mag + {{(MAG_W-1){1'b0}}, bump};
  assign inexact = half | sticky;
  assign ovf     = bump & (mag == MAX_FIN);
endmodule

// File: rtl/bfc_nan.sv
module bfc_nan
  import bfc_pkg::*;
(
  input  logic             sign,
  input  logic [PAY_W-1:0] payload,
  output logic [DST_W-1:0] nan_word
);
  always_comb begin
    if (payload == '0) nan_word = CANON_NAN;
    else               nan_word = {sign, {EXP_W{1'b1}}, 1'b1, payload};
  end
endmodule

// File: rtl/f32_to_bf16_cvt.sv
module f32_to_bf16_cvt
  import bfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [31:0]      in_word,
  output logic             out_vld,
  output logic [15:0]      out_word,
  output logic             out_inexact,
  output logic             out_ovf
);
  cls_e              cls;
  logic              sgn;
  logic [MAG_W-1:0]  mag_rnd;
  logic              rnd_inexact;
  logic              rnd_ovf;
  logic [DST_W-1:0]  nan_word;
  logic [DST_W-1:0]  nxt_word;
  logic              nxt_inexact;
  logic              nxt_ovf;

  assign sgn = in_word[SRC_W-1];

  bfc_classify u_cls (
    .word (in_word),
    .cls  (cls)
  );

  bfc_round u_rnd (
    .mag     (in_word[SRC_W-2:DROP_W]),
    .rem     (in_word[DROP_W-1:0]),
    .mag_rnd (mag_rnd),
    .inexact (rnd_inexact),
    .ovf     (rnd_ovf)
  );

  bfc_nan u_nan (
    .sign     (sgn),
    .payload  (in_word[DROP_W +: PAY_W]),
    .nan_word (nan_word)
  );

  always_comb begin
    nxt_word    = {sgn, {MAG_W{1'b0}}};
    nxt_inexact = 1'b0;
    nxt_ovf     = 1'b0;
    unique case (cls)
      CL_NORM: begin
        nxt_word    = {sgn, mag_rnd};
        nxt_inexact = rnd_inexact;
        nxt_ovf     = rnd_ovf;
      end
      CL_INF:  nxt_word = {sgn, INF_MAG};
      CL_NAN:  nxt_word = nan_word;
      default: nxt_word = {sgn, {MAG_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld     <= 1'b0;
      out_word    <= '0;
      out_inexact <= 1'b0;
      out_ovf     <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_word    <= nxt_word;
        out_inexact <= nxt_inexact;
        out_ovf     <= nxt_ovf;
      end
    end
  end
endmodule

// File: rtl/bfc_chk.sv
module bfc_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_vld,
  input logic [31:0] in_word,
  input logic        out_vld,
  input logic [15:0] out_word,
  input logic        out_inexact,
  input logic        out_ovf
);
  // R1 R4: sign survives for every non-NaN input
  p_sign_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_word[30:23] != 8'hFF) |=> out_word[15] == $past(in_word[31]));

  // R7
  p_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_word[30:23] == 8'h00) |=>
      (out_word[14:0] == 15'h0 && !out_inexact && !out_ovf));

  // R8
  p_inf_r8: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_word[30:0] == 31'h7F800000) |=>
      (out_word == {$past(in_word[31]), 15'h7F80} && !out_ovf));

  // R9: NaN result is quiet
  p_nan_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_word[30:23] == 8'hFF && in_word[22:0] != 23'h0) |=>
      (out_word[14:6] == 9'h1FF && !out_inexact));

  // R5
  p_ovf_inf_r5: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (out_word[14:0] == 15'h7F80 && out_inexact));

  // R10
  p_vld_r10: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!out_vld && $stable(out_word) && $stable(out_ovf)));
endmodule

bind f32_to_bf16_cvt bfc_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_vld      (in_vld),
  .in_word     (in_word),
  .out_vld     (out_vld),
  .out_word    (out_word),
  .out_inexact (out_inexact),
  .out_ovf     (out_ovf)
);

// File: tb/sim_f32_to_bf16_cvt.sv
module sim_f32_to_bf16_cvt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_vld;
  logic [15:0] out_word;
  logic        out_inexact;
  logic        out_ovf;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  f32_to_bf16_cvt u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word),
    .out_vld(out_vld), .out_word(out_word),
    .out_inexact(out_inexact), .out_ovf(out_ovf)
  );

  // {input, expected word, inexact, ovf}
  localparam int NV = 21;
  localparam logic [49:0] VEC [NV] = '{
    {32'h3F800000, 16'h3F80, 1'b0, 1'b0},  // R1 exact 1.0
    {32'h00800000, 16'h0080, 1'b0, 1'b0},  // R1 smallest normal
    {32'hC0490000, 16'hC049, 1'b0, 1'b0},  // R1 negative exact
    {32'h40490FDB, 16'h4049, 1'b1, 1'b0},  // R1 R6 below half
    {32'h3F807FFF, 16'h3F80, 1'b1, 1'b0},  // R2 just below half
    {32'h3F808001, 16'h3F81, 1'b1, 1'b0},  // R2 just above half
    {32'h3F808000, 16'h3F80, 1'b1, 1'b0},  // R3 tie, even kept
    {32'h3F818000, 16'h3F82, 1'b1, 1'b0},  // R3 tie, odd kept
    {32'hBF7FFFFF, 16'hBF80, 1'b1, 1'b0},  // R4 carry to exponent
    {32'h7F7FFFFF, 16'h7F80, 1'b1, 1'b1},  // R5 overflow
    {32'hFF7F8000, 16'hFF80, 1'b1, 1'b1},  // R5 tie overflow negative
    {32'h7F7F7FFF, 16'h7F7F, 1'b1, 1'b0},  // R5 max finite stays
    {32'h00000000, 16'h0000, 1'b0, 1'b0},  // R7 +0
    {32'h80000000, 16'h8000, 1'b0, 1'b0},  // R7 -0
    {32'h00400001, 16'h0000, 1'b0, 1'b0},  // R7 subnormal
    {32'h807FFFFF, 16'h8000, 1'b0, 1'b0},  // R7 negative subnormal
    {32'h7F800000, 16'h7F80, 1'b0, 1'b0},  // R8 +inf
    {32'hFF800000, 16'hFF80, 1'b0, 1'b0},  // R8 -inf
    {32'h7F800001, 16'h7FC0, 1'b0, 1'b0},  // R9 empty payload
    {32'hFFA50000, 16'hFFE5, 1'b0, 1'b0},  // R9 payload kept, quieted
    {32'h7FC00000, 16'h7FC0, 1'b0, 1'b0}   // R9 canonical
  };

  function automatic logic [17:0] model(input logic [31:0] x);
    int unsigned mag;
    int unsigned rem;
    logic [15:0] w;
    if (x[30:23] == 8'h00) return {x[31], 15'h0, 2'b00};
    if (x[30:23] == 8'hFF) begin
      if (x[22:0] == 0) return {x[31], 15'h7F80, 2'b00};
      if (x[21:16] == 0) return {16'h7FC0, 2'b00};
      return {x[31], 9'h1FF, x[21:16], 2'b00};
    end
    mag = x[30:16];
    rem = x[15:0];
    if (rem > 32768 || (rem == 32768 && (mag % 2) == 1)) mag = mag + 1;
    w = {x[31], mag[14:0]};
    return {w, rem != 0, mag == 32'h7F80};
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual word=%h inx=%b ovf=%b expected word=%h inx=%b ovf=%b",
               req, act[17:2], act[1], act[0], exp_v[17:2], exp_v[1], exp_v[0]);
    end
  endtask

  task automatic apply(input logic [31:0] x);
    @(negedge clk);
    in_vld  = 1'b1;
    in_word = x;
    @(negedge clk);
    in_vld  = 1'b0;
    checks++;
    if (out_vld !== 1'b1) begin
      errors++;
      $display("FAIL R10: out_vld actual=%b expected=1", out_vld);
    end
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check("R11 reset", {out_word, out_inexact, out_ovf}, 18'h0);
    checks++;
    if (out_vld !== 1'b0) begin
      errors++;
      $display("FAIL R11: out_vld actual=%b expected=0", out_vld);
    end
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][49:18]);
      check($sformatf("R1-table vec%0d", i), {out_word, out_inexact, out_ovf}, VEC[i][17:0]);
    end

    // R10: idle input changes do not move the held result
    apply(32'h3F818000);
    held = out_word;
    @(negedge clk);
    in_word = 32'h7F7FFFFF;
    repeat (3) @(negedge clk);
    check("R10 hold", {out_word, out_inexact, out_ovf}, {held, 2'b10});
    checks++;
    if (out_vld !== 1'b0) begin
      errors++;
      $display("FAIL R10: idle out_vld actual=%b expected=0", out_vld);
    end

    // R2 R3 R6: random sweep, half of them forced to a tie
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] x;
      x = $urandom;
      if (i % 2 == 0) x[15:0] = 16'h8000;
      apply(x);
      check("R2/R3 sweep", {out_word, out_inexact, out_ovf}, model(x));
    end

    // R11: reset in mid-run clears a nonzero result
    apply(32'hFF7FFFFF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11 midrun", {out_word, out_inexact, out_ovf}, 18'h0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule